// File: doc/BRIEF.md
# Configuration Stream Command Parser

This block sits at the front of a configuration loader. It accepts a configuration image one byte per valid/ready handshake, skips an optional leading comment region, hunts for a 32-bit synchronisation word and then decodes a sequence of commands. Each command is an opcode byte and three info bytes, followed by a payload whose length depends on the opcode. Multi-byte fields arrive most significant byte first. The parser captures the command payloads into output registers and streams dictionary entries out through a write port.

A running CRC16 covers the command bytes. It is compared against a transmitted check value wherever a command or the frame section calls for one. A programming command opens a frame data section. The parser then announces the setup word with a one-cycle strobe and forwards the frame bytes to a downstream port, each byte tagged with its frame index. Depending on the setup flags, a CRC check follows every frame or only the last frame, and padding bytes between frames are skipped. Sticky flags report a CRC mismatch, a device ID mismatch and an unrecognised opcode. The parser expects `rst_n` to be released synchronously to `clk`.

Top module: `cfg_stream_parser`

## Requirements
- R1: While `rst_n` is low, every register output, strobe and error flag is 0 and `in_ready` is 1.
- R2: Before synchronisation, the bytes FF then 00 open a comment region and the bytes 00 then FF close it. Nothing inside the region is decoded, including a sync word that appears there.
- R3: No command is decoded until the byte sequence FF FF BD B3 has been seen outside a comment. After it, each FF in opcode position is padding: it is skipped and does not enter the CRC.
- R4: Opcode 0x22 loads `ctrl0`, opcode 0xB4 loads `frame_addr` and opcode 0xC2 loads `usercode`, each from a 4-byte big-endian payload. Opcode 0x46 clears `frame_addr`. Each of these commands has 3 info bytes.
- R5: Opcode 0xE2 carries a 4-byte ID. If it differs from parameter `DEV_ID`, `err_id` is set and stays set until reset.
- R6: Opcode 0x02 carries 8 payload bytes. For each byte, `dict_we` pulses for one cycle in the cycle after the byte is accepted. `dict_idx` runs 7, 6, ..., 0 and `dict_data` holds the byte.
- R7: The CRC uses polynomial 0x8005, initial value 0 and most-significant-bit-first processing with no reflection. It covers the opcode, info and payload bytes of commands. When bit 7 of the first info byte is 1, two CRC bytes (high byte first) follow the payload; they are not accumulated, and a mismatch sets `err_crc` until reset.
- R8: The CRC keeps accumulating across commands and across checks. It is cleared only at the end of an opcode 0x3B command and at the end of a frame data section.
- R9: An opcode that is not padding and not in the recognised set {E2, 02, 22, 46, B4, C2, CE, 5E, 3B, 82, B8} sets `err_opcode` and returns the parser to sync hunting.
- R10: Opcode 0xCE sets `secure` and opcode 0x5E sets `done`; both hold until reset.
- R11: Opcodes 0x82 and 0xB8 pulse `prog_start` for one cycle. The 24 info bits are captured as the setup word: bit 23 enables the CRC, bit 22 selects a single check at the end, bits 21 and 20 are two dummy-control flags, bits 19:16 give the gap byte count and bits 15:0 give the frame count. `prog_compressed` is 1 for 0xB8 and 0 for 0x82.
- R12: In a frame section, exactly `FRAME_BYTES` bytes per frame appear on `fr_data`. `fr_index` counts frames from 0, and `fr_ready` low stalls `in_ready`.
- R13: With the CRC enabled and the end-only bit clear, two CRC bytes follow each frame. The checks continue the running CRC, which includes the programming command. With the end-only bit set, a single check follows the last frame. Gap bytes come after each frame's data (and its CRC, if any) and are not accumulated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| fr_valid | output | 1 | Frame byte valid |
| fr_data | output | 8 | Frame byte |
| fr_index | output | 16 | Index of the current frame within the section |
| fr_ready | input | 1 | Downstream accepts frame byte |
| dict_we | output | 1 | Dictionary write strobe |
| dict_idx | output | 3 | Dictionary entry index |
| dict_data | output | 8 | Dictionary entry value |
| ctrl0 | output | 32 | Control register 0 |
| frame_addr | output | 32 | Frame address register |
| usercode | output | 32 | User code register |
| secure | output | 1 | Security bit set |
| done | output | 1 | Done flag |
| prog_start | output | 1 | One-cycle strobe at start of a frame section |
| prog_compressed | output | 1 | Section was opened by the compressed-data opcode |
| prog_crc_en | output | 1 | Setup: CRC checking enabled |
| prog_crc_end | output | 1 | Setup: single check after the last frame |
| prog_pad_bits | output | 1 | Setup: dummy-bit flag |
| prog_pad_byte | output | 1 | Setup: dummy-byte flag |
| prog_gap | output | 4 | Setup: gap bytes after each frame |
| prog_nframes | output | 16 | Setup: number of frames |
| err_crc | output | 1 | Sticky CRC mismatch |
| err_id | output | 1 | Sticky device ID mismatch |
| err_opcode | output | 1 | Sticky unknown opcode |

## Verification
The bench builds the block with `FRAME_BYTES` set to 5 and `DEV_ID` set to a value other than the default. Five bytes is short and odd, so two-frame sections finish in a few dozen cycles and the frame-length counter never lines up with a power of two. The first frame section uses one gap byte and per-frame checks while the downstream port stalls in a repeating pattern. The second uses no gap bytes and a single check at the end, so both check placements, both gap cases and the backpressure path are all exercised.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

  typedef enum logic [3:0] {
    ST_HUNT  = 4'd0,
    ST_OPC   = 4'd1,
    ST_INFO  = 4'd2,
    ST_PAY   = 4'd3,
    ST_CCRC  = 4'd4,
    ST_FDATA = 4'd5,
    ST_FCRC  = 4'd6,
    ST_GAP   = 4'd7,
    ST_ECRC  = 4'd8
  } pst_e;

  localparam logic [7:0] OP_PAD      = 8'hFF;
  localparam logic [7:0] OP_IDCHK    = 8'hE2;
  localparam logic [7:0] OP_DICT     = 8'h02;
  localparam logic [7:0] OP_CTL0     = 8'h22;
  localparam logic [7:0] OP_FACLR    = 8'h46;
  localparam logic [7:0] OP_FALD     = 8'hB4;
  localparam logic [7:0] OP_UCODE    = 8'hC2;
  localparam logic [7:0] OP_SECURE   = 8'hCE;
  localparam logic [7:0] OP_DONE     = 8'h5E;
  localparam logic [7:0] OP_CRCRST   = 8'h3B;
  localparam logic [7:0] OP_PROG_RAW = 8'h82;
  localparam logic [7:0] OP_PROG_CMP = 8'hB8;

  typedef struct packed {
    logic        crc_en;
    logic        crc_end;
    logic        pad_bits;
    logic        pad_byte;
    logic [3:0]  gap;
    logic [15:0] nframes;
  } setup_t;

  function automatic logic op_known(input logic [7:0] op);
    case (op)
      OP_IDCHK, OP_DICT, OP_CTL0, OP_FACLR, OP_FALD, OP_UCODE,
      OP_SECURE, OP_DONE, OP_CRCRST, OP_PROG_RAW, OP_PROG_CMP: op_known = 1'b1;
      default: op_known = 1'b0;
    endcase
  endfunction

  function automatic logic op_is_prog(input logic [7:0] op);
    op_is_prog = (op == OP_PROG_RAW) || (op == OP_PROG_CMP);
  endfunction

  function automatic logic [3:0] op_pay_len(input logic [7:0] op);
    case (op)
      OP_IDCHK, OP_CTL0, OP_FALD, OP_UCODE: op_pay_len = 4'd4;
      OP_DICT:                              op_pay_len = 4'd8;
      default:                              op_pay_len = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/cfgp_crc16.sv
module cfgp_crc16 #(
  parameter int          CW   = 16,
  parameter logic [15:0] POLY = 16'h8005
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          feed,
  input  logic [7:0]    din,
  output logic [CW-1:0] crc
);

  logic [CW-1:0] crc_q, crc_d;

  function automatic logic [CW-1:0] step_byte(input logic [CW-1:0] c,
                                              input logic [7:0] d);
    logic [CW-1:0] r;
    logic          fbk;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fbk = r[CW-1] ^ d[i];
      r   = {r[CW-2:0], 1'b0};
      if (fbk) r = r ^ POLY[CW-1:0];
    end
    return r;
  endfunction

  always_comb begin
    crc_d = crc_q;
    if (clr)       crc_d = '0;
    else if (feed) crc_d = step_byte(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '0;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;

  // R8
  crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == '0));

endmodule

// File: rtl/cfgp_sync_hunt.sv
module cfgp_sync_hunt #(
  parameter logic [31:0] SYNC = 32'hFFFF_BDB3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] din,
  output logic       sync_hit
);

  logic [23:0] hist_q, hist_d;
  logic [1:0]  cnt_q, cnt_d;
  logic        cmt_q, cmt_d;

  always_comb begin
    hist_d   = hist_q;
    cnt_d    = cnt_q;
    cmt_d    = cmt_q;
    sync_hit = 1'b0;
    if (en) begin
      if (cmt_q) begin
        if ((cnt_q != 2'd0) && (hist_q[7:0] == 8'h00) && (din == 8'hFF)) begin
          cmt_d = 1'b0;
          cnt_d = 2'd0;
        end else begin
          hist_d = {hist_q[15:0], din};
          cnt_d  = (cnt_q == 2'd3) ? 2'd3 : cnt_q + 2'd1;
        end
      end else if ((cnt_q == 2'd3) && ({hist_q, din} == SYNC)) begin
        sync_hit = 1'b1;
        cnt_d    = 2'd0;
      end else if ((cnt_q != 2'd0) && (hist_q[7:0] == 8'hFF) && (din == 8'h00)) begin
        cmt_d = 1'b1;
        cnt_d = 2'd0;
      end else begin
        hist_d = {hist_q[15:0], din};
        cnt_d  = (cnt_q == 2'd3) ? 2'd3 : cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
      cmt_q  <= 1'b0;
    end else if (en) begin
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
      cmt_q  <= cmt_d;
    end
  end

  // R2
  cmt_no_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cmt_q) |-> !sync_hit);

endmodule

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser
  import cfgp_pkg::*;
#(
  parameter int          FRAME_BYTES = 8,
  parameter logic [31:0] DEV_ID      = 32'h1234_5A5A,
  parameter logic [15:0] CRC_POLY    = 16'h8005
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  output logic        fr_valid,
  output logic [7:0]  fr_data,
  output logic [15:0] fr_index,
  input  logic        fr_ready,
  output logic        dict_we,
  output logic [2:0]  dict_idx,
  output logic [7:0]  dict_data,
  output logic [31:0] ctrl0,
  output logic [31:0] frame_addr,
  output logic [31:0] usercode,
  output logic        secure,
  output logic        done,
  output logic        prog_start,
  output logic        prog_compressed,
  output logic        prog_crc_en,
  output logic        prog_crc_end,
  output logic        prog_pad_bits,
  output logic        prog_pad_byte,
  output logic [3:0]  prog_gap,
  output logic [15:0] prog_nframes,
  output logic        err_crc,
  output logic        err_id,
  output logic        err_opcode
);

  localparam int MAXC = (FRAME_BYTES > 16) ? FRAME_BYTES : 16;
  localparam int CW   = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] FB_LAST = CW'(FRAME_BYTES - 1);

  pst_e        state_q, state_d;
  logic [7:0]  op_q, op_d;
  logic [15:0] info_q, info_d;
  logic        cflag_q, cflag_d;
  logic [23:0] pay_q, pay_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [15:0] frm_q, frm_d;
  logic [7:0]  crchi_q, crchi_d;
  setup_t      setup_q, setup_d;
  logic        cmp_q, cmp_d;
  logic        pstart_q, pstart_d;
  logic        dwe_q, dwe_d;
  logic [2:0]  didx_q, didx_d;
  logic [7:0]  ddat_q, ddat_d;
  logic [31:0] ctrl0_q, ctrl0_d, fa_q, fa_d, uc_q, uc_d;
  logic        sec_q, sec_d, done_q, done_d;
  logic        ecrc_q, ecrc_d, eid_q, eid_d, eop_q, eop_d;

  logic        acc;
  logic        hunt_en;
  logic        sync_hit;
  logic        crc_feed, crc_clr;
  logic [15:0] crc_val;

  assign in_ready = (state_q == ST_FDATA) ? fr_ready : 1'b1;
  assign acc      = in_valid && in_ready;
  assign hunt_en  = acc && (state_q == ST_HUNT);
  assign fr_valid = in_valid && (state_q == ST_FDATA);
  assign fr_data  = in_data;
  assign fr_index = frm_q;

  cfgp_sync_hunt u_hunt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (hunt_en),
    .din      (in_data),
    .sync_hit (sync_hit)
  );

  cfgp_crc16 #(.CW(16), .POLY(CRC_POLY)) u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .feed  (crc_feed),
    .din   (in_data),
    .crc   (crc_val)
  );

  always_comb begin
    logic        go_gap, go_next, exec, chk_lo, cflag_now;
    logic [31:0] word;
    logic [3:0]  plen;
    setup_t      su;

    state_d  = state_q;
    op_d     = op_q;
    info_d   = info_q;
    cflag_d  = cflag_q;
    pay_d    = pay_q;
    cnt_d    = cnt_q;
    frm_d    = frm_q;
    crchi_d  = crchi_q;
    setup_d  = setup_q;
    cmp_d    = cmp_q;
    pstart_d = 1'b0;
    dwe_d    = 1'b0;
    didx_d   = didx_q;
    ddat_d   = ddat_q;
    ctrl0_d  = ctrl0_q;
    fa_d     = fa_q;
    uc_d     = uc_q;
    sec_d    = sec_q;
    done_d   = done_q;
    ecrc_d   = ecrc_q;
    eid_d    = eid_q;
    eop_d    = eop_q;
    crc_feed = 1'b0;
    crc_clr  = 1'b0;
    go_gap   = 1'b0;
    go_next  = 1'b0;
    exec     = 1'b0;
    chk_lo   = 1'b0;
    word     = {pay_q, in_data};
    plen     = op_pay_len(op_q);
    su       = {info_q, in_data};
    cflag_now = (state_q == ST_INFO) ? info_q[15] : cflag_q;

    if (acc) begin
      case (state_q)
        ST_HUNT: begin
          if (sync_hit) state_d = ST_OPC;
        end
        ST_OPC: begin
          if (in_data != OP_PAD) begin
            if (op_known(in_data)) begin
              crc_feed = 1'b1;
              op_d     = in_data;
              cnt_d    = '0;
              state_d  = ST_INFO;
            end else begin
              eop_d   = 1'b1;
              state_d = ST_HUNT;
            end
          end
        end
        ST_INFO: begin
          crc_feed = 1'b1;
          info_d   = {info_q[7:0], in_data};
          cnt_d    = cnt_q + CW'(1);
          if (cnt_q == CW'(2)) begin
            cflag_d = info_q[15];
            cnt_d   = '0;
            if (op_is_prog(op_q)) begin
              setup_d  = su;
              cmp_d    = (op_q == OP_PROG_CMP);
              pstart_d = 1'b1;
              frm_d    = '0;
              if (su.nframes == 16'd0) begin
                if (su.crc_en && su.crc_end) state_d = ST_ECRC;
                else begin
                  crc_clr = 1'b1;
                  state_d = ST_OPC;
                end
              end else begin
                state_d = ST_FDATA;
              end
            end else if (plen == 4'd0) begin
              exec = 1'b1;
            end else begin
              state_d = ST_PAY;
            end
          end
        end
        ST_PAY: begin
          crc_feed = 1'b1;
          pay_d    = {pay_q[15:0], in_data};
          cnt_d    = cnt_q + CW'(1);
          if (op_q == OP_DICT) begin
            dwe_d  = 1'b1;
            didx_d = ~cnt_q[2:0];
            ddat_d = in_data;
          end
          if (cnt_q == CW'(plen) - CW'(1)) exec = 1'b1;
        end
        ST_CCRC, ST_FCRC, ST_ECRC: begin
          if (cnt_q == '0) begin
            crchi_d = in_data;
            cnt_d   = CW'(1);
          end else begin
            chk_lo = 1'b1;
            cnt_d  = '0;
            if (state_q == ST_FCRC) begin
              go_gap = 1'b1;
            end else begin
              if ((state_q == ST_ECRC) || (op_q == OP_CRCRST)) crc_clr = 1'b1;
              state_d = ST_OPC;
            end
          end
        end
        ST_FDATA: begin
          crc_feed = 1'b1;
          cnt_d    = cnt_q + CW'(1);
          if (cnt_q == FB_LAST) begin
            cnt_d = '0;
            if (setup_q.crc_en && !setup_q.crc_end) state_d = ST_FCRC;
            else go_gap = 1'b1;
          end
        end
        ST_GAP: begin
          cnt_d = cnt_q + CW'(1);
          if (cnt_q == CW'(setup_q.gap) - CW'(1)) go_next = 1'b1;
        end
        default: state_d = ST_HUNT;
      endcase
    end

    if (chk_lo && ({crchi_q, in_data} != crc_val)) ecrc_d = 1'b1;

    if (exec) begin
      case (op_q)
        OP_IDCHK:  if (word != DEV_ID) eid_d = 1'b1;
        OP_CTL0:   ctrl0_d = word;
        OP_FALD:   fa_d    = word;
        OP_UCODE:  uc_d    = word;
        OP_FACLR:  fa_d    = '0;
        OP_SECURE: sec_d   = 1'b1;
        OP_DONE:   done_d  = 1'b1;
        default: ;
      endcase
      cnt_d = '0;
      if (cflag_now) begin
        state_d = ST_CCRC;
      end else begin
        if (op_q == OP_CRCRST) crc_clr = 1'b1;
        state_d = ST_OPC;
      end
    end

    if (go_gap) begin
      cnt_d = '0;
      if (setup_q.gap != 4'd0) state_d = ST_GAP;
      else go_next = 1'b1;
    end

    if (go_next) begin
      cnt_d = '0;
      if (frm_q == setup_q.nframes - 16'd1) begin
        if (setup_q.crc_en && setup_q.crc_end) state_d = ST_ECRC;
        else begin
          crc_clr = 1'b1;
          state_d = ST_OPC;
        end
      end else begin
        frm_d   = frm_q + 16'd1;
        state_d = ST_FDATA;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_HUNT;
      op_q     <= '0;
      info_q   <= '0;
      cflag_q  <= 1'b0;
      pay_q    <= '0;
      cnt_q    <= '0;
      frm_q    <= '0;
      crchi_q  <= '0;
      setup_q  <= '0;
      cmp_q    <= 1'b0;
      pstart_q <= 1'b0;
      dwe_q    <= 1'b0;
      didx_q   <= '0;
      ddat_q   <= '0;
      ctrl0_q  <= '0;
      fa_q     <= '0;
      uc_q     <= '0;
      sec_q    <= 1'b0;
      done_q   <= 1'b0;
      ecrc_q   <= 1'b0;
      eid_q    <= 1'b0;
      eop_q    <= 1'b0;
    end else begin
      pstart_q <= pstart_d;
      dwe_q    <= dwe_d;
      if (acc) begin
        state_q  <= state_d;
        op_q     <= op_d;
        info_q   <= info_d;
        cflag_q  <= cflag_d;
        pay_q    <= pay_d;
        cnt_q    <= cnt_d;
        frm_q    <= frm_d;
        crchi_q  <= crchi_d;
        setup_q  <= setup_d;
        cmp_q    <= cmp_d;
        didx_q   <= didx_d;
        ddat_q   <= ddat_d;
        ctrl0_q  <= ctrl0_d;
        fa_q     <= fa_d;
        uc_q     <= uc_d;
        sec_q    <= sec_d;
        done_q   <= done_d;
        ecrc_q   <= ecrc_d;
        eid_q    <= eid_d;
        eop_q    <= eop_d;
      end
    end
  end

  assign dict_we         = dwe_q;
  assign dict_idx        = didx_q;
  assign dict_data       = ddat_q;
  assign ctrl0           = ctrl0_q;
  assign frame_addr      = fa_q;
  assign usercode        = uc_q;
  assign secure          = sec_q;
  assign done            = done_q;
  assign prog_start      = pstart_q;
  assign prog_compressed = cmp_q;
  assign prog_crc_en     = setup_q.crc_en;
  assign prog_crc_end    = setup_q.crc_end;
  assign prog_pad_bits   = setup_q.pad_bits;
  assign prog_pad_byte   = setup_q.pad_byte;
  assign prog_gap        = setup_q.gap;
  assign prog_nframes    = setup_q.nframes;
  assign err_crc         = ecrc_q;
  assign err_id          = eid_q;
  assign err_opcode      = eop_q;

  // R7
  err_crc_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_crc |=> err_crc);

  // R5
  err_id_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_id |=> err_id);

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R11
  prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);

  // R12
  frame_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fr_valid |-> (fr_index < prog_nframes));

  // R6
  dict_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dict_we && $past(dict_we)) |-> (dict_idx == $past(dict_idx) - 3'd1));

endmodule

// File: tb/cfg_stream_parser_tb.sv
module cfg_stream_parser_tb;

  localparam int          CLK_PERIOD = 10;
  localparam int          FB         = 5;
  localparam logic [31:0] ID         = 32'hC0DE_0042;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        fr_valid;
  logic [7:0]  fr_data;
  logic [15:0] fr_index;
  logic        fr_ready;
  logic        dict_we;
  logic [2:0]  dict_idx;
  logic [7:0]  dict_data;
  logic [31:0] ctrl0, frame_addr, usercode;
  logic        secure, done, prog_start, prog_compressed;
  logic        prog_crc_en, prog_crc_end, prog_pad_bits, prog_pad_byte;
  logic [3:0]  prog_gap;
  logic [15:0] prog_nframes;
  logic        err_crc, err_id, err_opcode;

  int n_chk = 0;
  int n_bad = 0;
  int prog_pulses = 0;
  int cyc = 0;
  bit stall = 1'b0;
  logic [15:0] mcrc = 16'h0000;
  logic [23:0] fq[$];
  logic [10:0] dq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_stream_parser #(.FRAME_BYTES(FB), .DEV_ID(ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .fr_valid(fr_valid), .fr_data(fr_data),
    .fr_index(fr_index), .fr_ready(fr_ready), .dict_we(dict_we),
    .dict_idx(dict_idx), .dict_data(dict_data), .ctrl0(ctrl0),
    .frame_addr(frame_addr), .usercode(usercode), .secure(secure),
    .done(done), .prog_start(prog_start), .prog_compressed(prog_compressed),
    .prog_crc_en(prog_crc_en), .prog_crc_end(prog_crc_end),
    .prog_pad_bits(prog_pad_bits), .prog_pad_byte(prog_pad_byte),
    .prog_gap(prog_gap), .prog_nframes(prog_nframes), .err_crc(err_crc),
    .err_id(err_id), .err_opcode(err_opcode)
  );

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[15] ^ d[i]) r = {r[14:0], 1'b0} ^ 16'h8005;
      else              r = {r[14:0], 1'b0};
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // entered at a negedge, returns at a negedge after the byte is taken
  task automatic send(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic fb(input logic [7:0] b);
    send(b);
    mcrc = crc_upd(mcrc, b);
  endtask

  task automatic crc_tail(input bit good);
    logic [15:0] v = good ? mcrc : ~mcrc;
    send(v[15:8]);
    send(v[7:0]);
  endtask

  task automatic cmd32(input logic [7:0] op, input logic [7:0] info0,
                       input logic [31:0] w, input bit good);
    fb(op); fb(info0); fb(8'h00); fb(8'h00);
    fb(w[31:24]); fb(w[23:16]); fb(w[15:8]); fb(w[7:0]);
    if (info0[7]) crc_tail(good);
  endtask

  task automatic cmd0(input logic [7:0] op);
    fb(op); fb(8'h00); fb(8'h00); fb(8'h00);
  endtask

  task automatic frame(input int idx);
    for (int i = 0; i < FB; i++) begin
      logic [7:0] b = 8'((idx * 37 + i * 11) ^ 8'hA5);
      fq.push_back({16'(idx), b});
      fb(b);
    end
  endtask

  // monitor: compare frame bytes and dictionary writes against expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (fr_valid && fr_ready) begin
          if (fq.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R12 unexpected frame byte actual=%0h expected=none", {fr_index, fr_data});
          end else check("R12 frame byte/index", {fr_index, fr_data}, fq.pop_front());
        end
        if (dict_we) begin
          if (dq.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R6 unexpected dict write actual=%0h expected=none", {dict_idx, dict_data});
          end else check("R6 dict write", {dict_idx, dict_data}, dq.pop_front());
        end
        if (prog_start) prog_pulses++;
      end
    end
  end

  // downstream backpressure pattern
  initial begin
    fr_ready = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      fr_ready = !stall || ((cyc % 3) != 0);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL R12 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctrl0", ctrl0, 0);
    check("R1 frame_addr/usercode", {frame_addr, usercode}, 0);
    check("R1 flags", {secure, done, prog_start, dict_we, err_crc, err_id, err_opcode}, 0);
    check("R1 in_ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: a command before sync is not decoded
    send(8'h22); send(8'h00); send(8'h00); send(8'h00);
    send(8'h11); send(8'h22); send(8'h33); send(8'h44);
    check("R3 pre-sync ignored", ctrl0, 0);

    // R2: comment containing a sync word and a command
    send(8'hFF); send(8'h00);
    send(8'hFF); send(8'hFF); send(8'hBD); send(8'hB3);
    send(8'h22); send(8'h00); send(8'h00); send(8'h00);
    send(8'hAA); send(8'hBB); send(8'hCC); send(8'hDD);
    send(8'h00); send(8'hFF);
    check("R2 comment ignored", ctrl0, 0);

    send(8'hFF); send(8'hFF); send(8'hBD); send(8'hB3);
    send(8'hFF); send(8'hFF); send(8'hFF); send(8'hFF);

    cmd32(8'h22, 8'h00, 32'h4000_0000, 1'b1);
    check("R4 ctrl0", ctrl0, 32'h4000_0000);
    check("R3 padding skipped, no opcode error", err_opcode, 0);
    cmd32(8'hE2, 8'h00, ID, 1'b1);
    check("R5 matching id", err_id, 0);
    cmd32(8'hB4, 8'h00, 32'h0001_2345, 1'b1);
    check("R4 frame_addr load", frame_addr, 32'h0001_2345);
    cmd0(8'h46);
    check("R4 frame_addr clear", frame_addr, 0);
    cmd32(8'hC2, 8'h80, 32'hDEAD_BEEF, 1'b1);
    check("R4 usercode", usercode, 32'hDEAD_BEEF);
    check("R7 good crc over accumulated commands", err_crc, 0);

    // R6 dictionary
    cmd0(8'h02);
    for (int k = 7; k >= 0; k--) begin
      logic [7:0] d = 8'(8'h10 + k * 3);
      dq.push_back({3'(k), d});
      fb(d);
    end
    send(8'hFF); send(8'hFF);
    cmd32(8'h22, 8'h80, 32'h0BAD_F00D, 1'b1);
    check("R8 crc continues across checks", err_crc, 0);
    check("R6 all dict writes seen", dq.size(), 0);

    // R8 clear by reset-crc opcode
    cmd0(8'h3B);
    mcrc = 16'h0000;
    cmd32(8'h22, 8'h80, 32'h1234_5678, 1'b1);
    check("R8 crc cleared by 3B", err_crc, 0);

    // R11/R13 compressed section, per-frame checks, one gap byte, stalls
    fb(8'hB8); fb(8'h81); fb(8'h00); fb(8'h02);
    stall = 1'b1;
    frame(0); crc_tail(1'b1); send(8'hFF);
    frame(1); crc_tail(1'b1); send(8'hFF);
    stall = 1'b0;
    mcrc = 16'h0000;
    check("R11 compressed flag", prog_compressed, 1);
    check("R11 setup fields", {prog_crc_en, prog_crc_end, prog_pad_bits, prog_pad_byte, prog_gap, prog_nframes},
          {1'b1, 1'b0, 1'b0, 1'b0, 4'd1, 16'd2});
    check("R13 per-frame crc ok", err_crc, 0);
    check("R12 frames drained", fq.size(), 0);

    // R13 raw section, end-only check, no gap
    fb(8'h82); fb(8'hC0); fb(8'h00); fb(8'h02);
    frame(0); frame(1); crc_tail(1'b1);
    mcrc = 16'h0000;
    check("R11 raw flags", {prog_compressed, prog_crc_end, prog_gap}, {1'b0, 1'b1, 4'd0});
    check("R11 prog_start pulses", prog_pulses, 2);
    check("R13 end-only crc ok", err_crc, 0);
    cmd32(8'h22, 8'h80, 32'hCAFE_F00D, 1'b1);
    check("R8 crc cleared after frame section", err_crc, 0);

    cmd0(8'hCE);
    check("R10 secure", {secure, done}, 2'b10);
    cmd0(8'h5E);
    check("R10 done", {secure, done}, 2'b11);

    cmd32(8'hE2, 8'h00, ID ^ 32'h1, 1'b1);
    check("R5 id mismatch", err_id, 1);

    cmd32(8'h22, 8'h80, 32'h0102_0304, 1'b0);
    check("R7 bad crc flagged", err_crc, 1);
    cmd32(8'h22, 8'h80, 32'h0506_0708, 1'b1);
    check("R7 crc error sticky", err_crc, 1);
    check("R4 ctrl0 after checks", ctrl0, 32'h0506_0708);

    // R9 unknown opcode
    send(8'h77);
    check("R9 unknown opcode flag", err_opcode, 1);
    send(8'h22); send(8'h00); send(8'h00); send(8'h00);
    send(8'h55); send(8'h66); send(8'h77); send(8'h88);
    check("R9 back to hunt", ctrl0, 32'h0506_0708);
    send(8'hFF); send(8'hFF); send(8'hBD); send(8'hB3);
    cmd32(8'h22, 8'h00, 32'h99AA_BBCC, 1'b1);
    check("R9 resync decodes", ctrl0, 32'h99AA_BBCC);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

endmodule